// File: doc/BRIEF.md
# Enable-Framed 4K x 1 Static Memory

This block is a clock-synchronous model of a 4096-word by 1-bit static memory. A single active-low chip enable frames each access. The clock edge that first sees the enable low after seeing it high starts a memory cycle and captures the address. The address pins are then ignored until the enable returns high. An active-low write strobe selects whether the window is a read or a write.

In a read window, the output-enable flag (which stands in for a tri-state driver) rises first. The data bit becomes valid a fixed number of clocks later. In a write window, the output stays disabled and the data bit is committed at the end of the cycle.

Taking the enable high ends the cycle and shuts the output off. If the enable is high for too few clocks before the next cycle starts, a sticky timing-error flag is raised. A synchronous reset clears that flag and the whole array.

Top module: `latched_sram`

## Requirements
- R1: The array holds 2^ADDR_W (4096 by default) one-bit words. After reset every word reads as 0.
- R2: The address is captured at the clock edge where `ce_n` is sampled low and the previous sample was high. Address changes later in the same window do not change which word is read, and `dout` stays stable while `valid` is high.
- R3: Whenever `valid` is low, `dout` is 0. After reset `oe`, `valid`, `dout` and `timing_err` are all 0.
- R4: In a read window, `oe` is still 0 after the capturing edge and becomes 1 after the next edge.
- R5: `valid` becomes 1 after the edge ACCESS_CYCLES (default 2) clocks past the capturing edge. While `valid` is 1, `oe` is also 1 and `dout` equals the stored bit at the captured address. For ACCESS_CYCLES above 1, `oe` is already 1 one clock before `valid` rises.
- R6: `oe` and `valid` are both 0 after any edge where `ce_n` is sampled high.
- R7: A window in which `we_n` is sampled low at any edge is a write window. In a write window `oe` and `valid` stay 0. The stored bit is the `din` value from the last edge where `we_n` was sampled low. It is committed at the edge where `ce_n` is next sampled high. `din` values sampled while `we_n` is high are ignored.
- R8: `timing_err` becomes 1 at a capturing edge that had fewer than MIN_PRECHARGE (default 2) preceding edges with `ce_n` high. The first window after reset is not flagged. Once set, the flag stays 1.
- R9: Synchronous reset (`rst_n` low at a clock edge) clears `timing_err` and returns every word to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable; each low period is one cycle |
| we_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Word address, captured at the start of a cycle |
| din | input | 1 | Write data |
| dout | output | 1 | Read data, 0 unless valid |
| oe | output | 1 | Output driver enabled |
| valid | output | 1 | Read data valid |
| timing_err | output | 1 | Sticky short-precharge flag |

## Verification
The assertions assume that `ce_n` is high when reset is released, so that the first low sample is a genuine cycle start. The stability check on `dout` relies on the fact that no write can commit while a read window is open; this holds because writes commit only when the enable rises. The bench changes every input only on falling clock edges. It releases reset with the enable high, and it holds the enable high for exactly MIN_PRECHARGE edges between windows. The single exception is one deliberate short gap used to provoke the timing flag.

// File: rtl/sram_pkg.sv
package sram_pkg;

    // Write request handed from the cycle controller to the storage array.
    typedef struct packed {
        logic en;
        logic data;
    } sram_wreq_t;

endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_pkg::*;
#(
    parameter int ADDR_W        = 12,
    parameter int ACCESS_CYCLES = 2,
    parameter int MIN_PRECHARGE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic [ADDR_W-1:0] addr_o,
    output sram_wreq_t        wreq_o,
    output logic              oe_o,
    output logic              valid_o,
    output logic              err_o
);

    localparam int CNT_W = $clog2(ACCESS_CYCLES + 1);
    localparam int HI_W  = $clog2(MIN_PRECHARGE + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ACCESS_CYCLES);
    localparam logic [HI_W-1:0]  HI_MAX  = HI_W'(MIN_PRECHARGE);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;     // captured word address
        logic [CNT_W-1:0]  cnt;      // clocks since cycle start, saturating
        logic [HI_W-1:0]   hi;       // enable-high samples, saturating
        logic              active;   // inside an enable-low window
        logic              wr;       // window marked as write
        logic              wdata;    // last data seen with strobe low
        logic              ce_prev;  // previous enable sample
        logic              err;      // sticky timing error
    } ctl_t;

    ctl_t       s_q, s_d;
    sram_wreq_t wreq_d;

    always_comb begin
        s_d         = s_q;
        wreq_d      = '0;
        s_d.ce_prev = ce_n;
        if (ce_n) begin
            // Enable high: close any open window, count precharge.
            if (s_q.hi != HI_MAX) begin
                s_d.hi = s_q.hi + 1'b1;
            end
            if (s_q.active) begin
                wreq_d.en   = s_q.wr;
                wreq_d.data = s_q.wdata;
            end
            s_d.active = 1'b0;
            s_d.wr     = 1'b0;
            s_d.cnt    = '0;
        end else if (s_q.ce_prev) begin
            // Cycle start: capture address, judge the precharge gap.
            s_d.active = 1'b1;
            s_d.addr   = addr;
            s_d.cnt    = '0;
            s_d.wr     = !we_n;
            s_d.wdata  = we_n ? s_q.wdata : din;
            s_d.hi     = '0;
            if (s_q.hi < HI_MAX) begin
                s_d.err = 1'b1;
            end
        end else if (s_q.active) begin
            if (s_q.cnt != CNT_MAX) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
            if (!we_n) begin
                s_d.wr    = 1'b1;
                s_d.wdata = din;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.hi      <= HI_MAX;
            s_q.ce_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign addr_o  = s_q.addr;
    assign wreq_o  = wreq_d;
    assign oe_o    = s_q.active && !s_q.wr && (s_q.cnt != '0);
    assign valid_o = s_q.active && !s_q.wr && (s_q.cnt == CNT_MAX);
    assign err_o   = s_q.err;

endmodule

// File: rtl/sram_array.sv
module sram_array
    import sram_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sram_wreq_t        wreq,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] mem_q, mem_d;

    always_comb begin
        mem_d = mem_q;
        if (wreq.en) begin
            mem_d[addr] = wreq.data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_o = mem_q[addr];

endmodule

// File: rtl/latched_sram.sv
module latched_sram
    import sram_pkg::*;
#(
    parameter int ADDR_W        = 12,
    parameter int ACCESS_CYCLES = 2,
    parameter int MIN_PRECHARGE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              dout,
    output logic              oe,
    output logic              valid,
    output logic              timing_err
);

    logic [ADDR_W-1:0] cyc_addr;
    sram_wreq_t        wreq;
    logic              rd_bit;

    sram_ctrl #(
        .ADDR_W       (ADDR_W),
        .ACCESS_CYCLES(ACCESS_CYCLES),
        .MIN_PRECHARGE(MIN_PRECHARGE)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .we_n   (we_n),
        .addr   (addr),
        .din    (din),
        .addr_o (cyc_addr),
        .wreq_o (wreq),
        .oe_o   (oe),
        .valid_o(valid),
        .err_o  (timing_err)
    );

    sram_array #(
        .ADDR_W(ADDR_W)
    ) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .wreq (wreq),
        .addr (cyc_addr),
        .rd_o (rd_bit)
    );

    assign dout = valid & rd_bit;

endmodule

// File: rtl/sram_checker.sv
module sram_checker #(
    parameter int ACCESS_CYCLES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic we_n,
    input logic dout,
    input logic oe,
    input logic valid,
    input logic timing_err
);

    assert_idle_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (!oe && !valid));

    assert_dout_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> !dout);

    assert_valid_needs_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> oe);

    assert_no_early_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $past(ce_n)) |=> !oe);

    assert_write_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |=> (!oe && !valid));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timing_err |=> timing_err);

    assert_read_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(valid)) |-> $stable(dout));

    if (ACCESS_CYCLES > 1) begin : g_phase
        assert_oe_before_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(valid) |-> $past(oe));
    end

endmodule

bind latched_sram sram_checker #(
    .ACCESS_CYCLES(ACCESS_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .dout      (dout),
    .oe        (oe),
    .valid     (valid),
    .timing_err(timing_err)
);

// File: tb/latched_sram_bench.sv
`timescale 1ns/1ps
module latched_sram_bench;

    localparam int AW   = 12;
    localparam int NW   = 1 << AW;
    localparam int PREC = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce_n;
    logic          we_n;
    logic [AW-1:0] addr;
    logic          din;
    logic          dout;
    logic          oe;
    logic          valid;
    logic          timing_err;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    latched_sram u_latched_sram (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .addr      (addr),
        .din       (din),
        .dout      (dout),
        .oe        (oe),
        .valid     (valid),
        .timing_err(timing_err)
    );

    function automatic logic pat(input logic [AW-1:0] a);
        return a[0] ^ a[3] ^ a[7] ^ a[11] ^ (a[5] & a[2]);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Enable high for n edges; check outputs after the first (R6, R3).
    task automatic precharge(input int n);
        ce_n = 1'b1;
        we_n = 1'b1;
        step();
        chk("R6 oe off after enable high", oe, 1'b0);
        chk("R6 valid off after enable high", valid, 1'b0);
        chk("R3 dout zero when not valid", dout, 1'b0);
        for (int i = 1; i < n; i++) step();
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic exp, input int hi);
        ce_n = 1'b0;
        we_n = 1'b1;
        addr = a;
        step();
        chk("R4 oe low after capture edge", oe, 1'b0);
        addr = ~a;                       // must be ignored (R2)
        step();
        chk("R4 oe high one clock later", oe, 1'b1);
        chk("R5 valid still low", valid, 1'b0);
        step();
        chk("R5 valid high", valid, 1'b1);
        chk("R2 dout from captured address", dout, exp);
        precharge(hi);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic d);
        ce_n = 1'b0;
        we_n = 1'b0;
        addr = a;
        din  = d;
        step();
        chk("R7 oe low in write", oe, 1'b0);
        addr = ~a;
        step();
        we_n = 1'b1;
        din  = ~d;                       // strobe high: ignored (R7)
        step();
        chk("R7 oe low in write", oe, 1'b0);
        chk("R7 valid low in write", valid, 1'b0);
        precharge(PREC);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        ce_n  = 1'b1;
        we_n  = 1'b1;
        addr  = '0;
        din   = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R3 reset oe", oe, 1'b0);
        chk("R3 reset valid", valid, 1'b0);
        chk("R3 reset dout", dout, 1'b0);
        chk("R3 reset timing_err", timing_err, 1'b0);

        // R1: unwritten words read 0.
        for (int i = 0; i < 8; i++) rd(AW'(i * 517 + 3), 1'b0, PREC);
        chk("R8 first window not flagged", timing_err, 1'b0);

        // R1/R7: fill every word, then read every word back.
        for (int i = 0; i < NW; i++) wr(AW'(i), pat(AW'(i)));
        for (int i = 0; i < NW; i++) rd(AW'(i), pat(AW'(i)), PREC);
        chk("R8 no error with full precharge", timing_err, 1'b0);

        // R8: short gap sets the flag, which then stays set.
        rd(AW'(7), pat(AW'(7)), 1);
        rd(AW'(8), pat(AW'(8)), PREC);
        chk("R8 short precharge flagged", timing_err, 1'b1);
        rd(AW'(9), pat(AW'(9)), PREC);
        chk("R8 flag sticky", timing_err, 1'b1);

        // R7: overwrite with the opposite value.
        wr(AW'(9), ~pat(AW'(9)));
        rd(AW'(9), ~pat(AW'(9)), PREC);

        // R9: reset clears flag and memory (word 1 holds 1).
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        chk("R9 reset clears timing_err", timing_err, 1'b0);
        rd(AW'(1), 1'b0, PREC);
        chk("R9 no flag after reset", timing_err, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule